// File: doc/BRIEF.md
# Word Access Byte Sequencer

This block sits between an agent that issues 16-bit loads and stores and a byte-wide memory bus with 24-bit addresses. It takes one word request at a time and splits it into two byte cycles. The second byte's address is formed under one of three wrap modes. A store may be issued high byte first. The assembled load word comes back with a one-cycle done pulse. Device decoding sits outside the block. The bus only reports, per byte, whether the address was mapped.

While a DMA engine owns the bus, any byte whose middle address byte selects the register page (0x21) is kept off the bus. A load from a suppressed or unmapped byte returns the open-bus byte, which is the last value actually read from the bus. That value is exported so that neighbouring logic can use it.

Top module: `word_byte_seq`

## Requirements
- R1: `req_ready_o` is high exactly when the sequencer is idle. A request is taken on a cycle with `req_valid_i` and `req_ready_o` both high. No bus cycle is driven while `req_ready_o` is high.
- R2: The second address is formed from `req_wrap_i`. Code 1 increments only bits 7:0 and carries nothing out. Code 2 increments only bits 15:0. Codes 0 and 3 increment the full 24-bit address.
- R3: A load always reads the first address before the second address. `rsp_rdata_o[7:0]` comes from the first address and `rsp_rdata_o[15:8]` from the second.
- R4: With `req_hi_first_i` = 0, a store writes `req_wdata_i[7:0]` to the first address and then `req_wdata_i[15:8]` to the second. With `req_hi_first_i` = 1, it writes the high byte to the second address first and the low byte to the first address after it. For loads the bit is ignored.
- R5: While `dma_active_i` is high, a byte whose address bits 15:8 equal 0x21 drives no bus cycle. A suppressed load byte returns `open_bus_o`. A suppressed store byte is dropped. With `dma_active_i` low, the same address is issued normally.
- R6: A load byte completed with `bus_unmapped_i` high returns the current `open_bus_o`. A word with both bytes unmapped therefore returns that byte in both halves.
- R7: `open_bus_o` resets to 0. It takes the bus data of every completed load byte that is mapped and not suppressed, including a first byte at a wrap boundary. It keeps its value otherwise, which covers stores, unmapped bytes and suppressed bytes.
- R8: A byte cycle holds its address, strobe and data until `bus_ready_i` is high. `rsp_done_o` pulses for exactly one cycle, in the cycle after the second byte finishes. In that same cycle `rsp_rdata_o` is valid for loads.
- R9: After reset, `req_ready_o` = 1 and `bus_valid_o`, `rsp_done_o` and `open_bus_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 24 | Address of the low byte |
| req_wrap_i | input | 2 | Wrap mode: 0 flat, 1 page, 2 bank, 3 flat |
| req_hi_first_i | input | 1 | Store high byte first |
| req_wdata_i | input | 16 | Store data |
| dma_active_i | input | 1 | DMA owns the bus |
| bus_valid_o | output | 1 | Byte cycle active |
| bus_addr_o | output | 24 | Byte address |
| bus_we_o | output | 1 | Byte write strobe |
| bus_wdata_o | output | 8 | Byte write data |
| bus_ready_i | input | 1 | Byte cycle completes this clock |
| bus_rdata_i | input | 8 | Byte read data |
| bus_unmapped_i | input | 1 | Address not decoded by any device |
| rsp_done_o | output | 1 | Word access finished (pulse) |
| rsp_rdata_o | output | 16 | Assembled load word |
| open_bus_o | output | 8 | Current open-bus byte |

## Verification
The bench builds the block with its default 24-bit address, page field at bits 15:8 and register page 0x21. This puts the page, bank and full-address carries within direct reach, for example 0x0012FF, 0x03FFFF and 0x7EFFFF. It also lets addresses such as 0x0020FF and 0x0021FF cross into and out of the protected page under DMA. Bank 0x7F is answered as unmapped, so a word can straddle a mapped and an unmapped byte. Bus ready is held low on every third cycle to exercise stalls.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  typedef enum logic [1:0] {
    WRAP_FLAT = 2'd0,
    WRAP_PAGE = 2'd1,
    WRAP_BANK = 2'd2,
    WRAP_ALT  = 2'd3
  } wrap_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/wbs_next_addr.sv
module wbs_next_addr #(
  parameter int AW     = 24,
  parameter int PAGE_W = 8,
  parameter int BANK_W = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    wrap_i,
  output logic [AW-1:0] next_o
);
  import wbs_pkg::*;

  logic [PAGE_W-1:0] page_inc;
  logic [BANK_W-1:0] bank_inc;
  logic [AW-1:0]     flat_inc;

  assign page_inc = addr_i[PAGE_W-1:0] + 1'b1;
  assign bank_inc = addr_i[BANK_W-1:0] + 1'b1;
  assign flat_inc = addr_i + 1'b1;

  always_comb begin
    unique case (wrap_e'(wrap_i))
      WRAP_PAGE: next_o = {addr_i[AW-1:PAGE_W], page_inc};
      WRAP_BANK: next_o = {addr_i[AW-1:BANK_W], bank_inc};
      default:   next_o = flat_inc;
    endcase
  end
endmodule

// File: rtl/wbs_open_bus.sv
module wbs_open_bus #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= data_i;
  end
endmodule

// File: rtl/wbs_ctrl.sv
module wbs_ctrl #(
  parameter int          AW       = 24,
  parameter int          DW       = 8,
  parameter int          PAGE_W   = 8,
  parameter int          BANK_W   = 16,
  parameter logic [7:0]  REG_PAGE = 8'h21,
  localparam int         WW       = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [AW-1:0] req_next_i,
  input  logic          req_hi_first_i,
  input  logic [WW-1:0] req_wdata_i,
  input  logic          dma_active_i,
  output logic          bus_valid_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_we_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ready_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_unmapped_i,
  input  logic [DW-1:0] open_bus_i,
  output logic          ob_upd_o,
  output logic          rsp_done_o,
  output logic [WW-1:0] rsp_rdata_o
);
  import wbs_pkg::*;

  phase_e        state_q;
  logic [AW-1:0] addr_q, next_q;
  logic          wr_q, hi_first_q;
  logic [WW-1:0] wdata_q;
  logic [DW-1:0] lo_q;

  logic          busy, swap, at_second, sup, step;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rd_byte;

  assign busy        = (state_q != ST_IDLE);
  assign req_ready_o = !busy;
  // reverse store order visits the second address first
  assign swap        = wr_q && hi_first_q;
  assign at_second   = (state_q == ST_FIRST) ? swap : !swap;
  assign cur_addr    = at_second ? next_q : addr_q;
  assign sup         = dma_active_i && (cur_addr[BANK_W-1:PAGE_W] == REG_PAGE[BANK_W-PAGE_W-1:0]);
  assign step        = busy && (sup || bus_ready_i);

  assign bus_valid_o = busy && !sup;
  assign bus_addr_o  = cur_addr;
  assign bus_we_o    = busy && wr_q;
  assign bus_wdata_o = at_second ? wdata_q[WW-1:DW] : wdata_q[DW-1:0];

  assign rd_byte  = (sup || bus_unmapped_i) ? open_bus_i : bus_rdata_i;
  assign ob_upd_o = busy && !sup && bus_ready_i && !wr_q && !bus_unmapped_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      next_q      <= '0;
      wr_q        <= 1'b0;
      hi_first_q  <= 1'b0;
      wdata_q     <= '0;
      lo_q        <= '0;
      rsp_done_o  <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q    <= ST_FIRST;
            addr_q     <= req_addr_i;
            next_q     <= req_next_i;
            wr_q       <= req_write_i;
            hi_first_q <= req_hi_first_i;
            wdata_q    <= req_wdata_i;
          end
        end
        ST_FIRST: begin
          if (step) begin
            state_q <= ST_SECOND;
            if (!wr_q) lo_q <= rd_byte;
          end
        end
        ST_SECOND: begin
          if (step) begin
            state_q    <= ST_IDLE;
            rsp_done_o <= 1'b1;
            if (!wr_q) rsp_rdata_o <= {rd_byte, lo_q};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/word_byte_seq.sv
module word_byte_seq #(
  parameter int         AW       = 24,
  parameter int         DW       = 8,
  parameter int         PAGE_W   = 8,
  parameter int         BANK_W   = 16,
  parameter logic [7:0] REG_PAGE = 8'h21,
  localparam int        WW       = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_wrap_i,
  input  logic          req_hi_first_i,
  input  logic [WW-1:0] req_wdata_i,
  input  logic          dma_active_i,
  output logic          bus_valid_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_we_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ready_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_unmapped_i,
  output logic          rsp_done_o,
  output logic [WW-1:0] rsp_rdata_o,
  output logic [DW-1:0] open_bus_o
);
  logic [AW-1:0] req_next;
  logic          ob_upd;

  wbs_next_addr #(.AW(AW), .PAGE_W(PAGE_W), .BANK_W(BANK_W)) i_next (
    .addr_i (req_addr_i),
    .wrap_i (req_wrap_i),
    .next_o (req_next)
  );

  wbs_open_bus #(.DW(DW)) i_ob (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (ob_upd),
    .data_i (bus_rdata_i),
    .q_o    (open_bus_o)
  );

  wbs_ctrl #(
    .AW(AW), .DW(DW), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .REG_PAGE(REG_PAGE)
  ) i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_write_i    (req_write_i),
    .req_addr_i     (req_addr_i),
    .req_next_i     (req_next),
    .req_hi_first_i (req_hi_first_i),
    .req_wdata_i    (req_wdata_i),
    .dma_active_i   (dma_active_i),
    .bus_valid_o    (bus_valid_o),
    .bus_addr_o     (bus_addr_o),
    .bus_we_o       (bus_we_o),
    .bus_wdata_o    (bus_wdata_o),
    .bus_ready_i    (bus_ready_i),
    .bus_rdata_i    (bus_rdata_i),
    .bus_unmapped_i (bus_unmapped_i),
    .open_bus_i     (open_bus_o),
    .ob_upd_o       (ob_upd),
    .rsp_done_o     (rsp_done_o),
    .rsp_rdata_o    (rsp_rdata_o)
  );
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
  parameter int         AW       = 24,
  parameter int         DW       = 8,
  parameter logic [7:0] REG_PAGE = 8'h21
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          dma_active_i,
  input logic          bus_valid_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_we_o,
  input logic          bus_ready_i,
  input logic          rsp_done_o,
  input logic [DW-1:0] open_bus_o
);
  AST_NO_BUS_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !req_ready_o); // R1

  AST_DMA_PAGE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && dma_active_i) |-> (bus_addr_o[15:8] != REG_PAGE)); // R5

  AST_OPEN_BUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_o && bus_ready_i && !bus_we_o) |=> $stable(open_bus_o)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R8

  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> req_ready_o); // R8
endmodule

bind word_byte_seq wbs_checker #(.AW(AW), .DW(DW), .REG_PAGE(REG_PAGE)) i_wbs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .dma_active_i (dma_active_i),
  .bus_valid_o  (bus_valid_o),
  .bus_addr_o   (bus_addr_o),
  .bus_we_o     (bus_we_o),
  .bus_ready_i  (bus_ready_i),
  .rsp_done_o   (rsp_done_o),
  .open_bus_o   (open_bus_o)
);

// File: tb/test_word_byte_seq.sv
module test_word_byte_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_hi_first = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_wrap = '0;
  logic [15:0] req_wdata = '0;
  logic        dma = 1'b0;
  logic        bus_valid, bus_we, bus_ready = 1'b0, bus_unm;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, open_bus;
  logic        rsp_done;
  logic [15:0] rsp_rdata;

  int vectors = 0, miscompares = 0;
  logic [7:0]  exp_ob = 8'h00;
  logic [32:0] exp_q[$];   // {we, addr, data}

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  assign bus_rdata = mem_f(bus_addr);
  assign bus_unm   = (bus_addr[23:16] == 8'h7F);

  word_byte_seq i_word_byte_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wrap_i(req_wrap), .req_hi_first_i(req_hi_first),
    .req_wdata_i(req_wdata), .dma_active_i(dma),
    .bus_valid_o(bus_valid), .bus_addr_o(bus_addr), .bus_we_o(bus_we),
    .bus_wdata_o(bus_wdata), .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata),
    .bus_unmapped_i(bus_unm), .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .open_bus_o(open_bus)
  );

  task automatic chk(string tag, logic [32:0] got, logic [32:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // bus ready low every third cycle
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      bus_ready = (cyc % 3) != 0;
    end
  end

  // per-clock bus monitor against the model's expected transactions
  logic        prev_stall = 1'b0;
  logic [23:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk("R8 hold during stall", {8'h0, bus_valid, bus_addr}, {8'h0, 1'b1, prev_addr});
      if (bus_valid && bus_ready) begin
        if (exp_q.size() == 0) chk("R5 unexpected bus cycle", {bus_we, bus_addr, bus_wdata}, 33'h0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk("R2 R3 R4 bus cycle", {bus_we, bus_addr, bus_we ? bus_wdata : 8'h00}, e);
        end
      end
      if (bus_valid) chk("R1 ready low while busy", {32'h0, req_ready}, 33'h0);
      prev_stall = bus_valid && !bus_ready;
      prev_addr  = bus_addr;
    end
  end

  function automatic logic [23:0] nxt(logic [23:0] a, logic [1:0] w);
    case (w)
      2'd1: return {a[23:8], a[7:0] + 8'd1};
      2'd2: return {a[23:16], a[15:0] + 16'd1};
      default: return a + 24'd1;
    endcase
  endfunction

  task automatic access(string tag, logic wr, logic [23:0] a, logic [1:0] w,
                        logic hf, logic [15:0] wd, logic d);
    logic [23:0] a1;
    logic [7:0]  v[2];
    logic [15:0] exp_word;
    a1 = nxt(a, w);
    if (!wr) begin
      for (int i = 0; i < 2; i++) begin
        logic [23:0] aa;
        aa = i ? a1 : a;
        if (d && aa[15:8] == 8'h21) v[i] = exp_ob;
        else begin
          exp_q.push_back({1'b0, aa, 8'h00});
          if (aa[23:16] == 8'h7F) v[i] = exp_ob;
          else begin v[i] = mem_f(aa); exp_ob = v[i]; end
        end
      end
      exp_word = {v[1], v[0]};
    end else begin
      exp_word = '0;
      for (int i = 0; i < 2; i++) begin
        logic hi;
        logic [23:0] aa;
        hi = hf ? (i == 0) : (i == 1);
        aa = hi ? a1 : a;
        if (!(d && aa[15:8] == 8'h21)) exp_q.push_back({1'b1, aa, hi ? wd[15:8] : wd[7:0]});
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    dma = d; req_write = wr; req_addr = a; req_wrap = w; req_hi_first = hf; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 busy after accept"}, {32'h0, req_ready}, 33'h0);
    while (!rsp_done) @(negedge clk);
    if (!wr) chk({tag, " word"}, {17'h0, rsp_rdata}, {17'h0, exp_word});
    chk({tag, " R7 open bus"}, {25'h0, open_bus}, {25'h0, exp_ob});
    chk({tag, " R4 R5 all cycles seen"}, exp_q.size(), 33'h0);
    exp_q.delete();
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, {31'h0, rsp_done, req_ready}, 33'h1);
    dma = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hang exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk("R9 reset state", {29'h0, req_ready, bus_valid, rsp_done, 1'b0}, 33'h8);
    chk("R9 open bus reset", {25'h0, open_bus}, 33'h0);
    rst_n = 1'b1;
    access("R3 flat read",          0, 24'h001234, 2'd0, 0, 16'h0, 0);
    access("R2 R7 page wrap read",  0, 24'h0012FF, 2'd1, 0, 16'h0, 0);
    access("R2 bank wrap read",     0, 24'h03FFFF, 2'd2, 0, 16'h0, 0);
    access("R2 flat carry read",    0, 24'h03FFFF, 2'd0, 0, 16'h0, 0);
    access("R2 code3 flat read",    0, 24'h0000FF, 2'd3, 0, 16'h0, 0);
    access("R3 R4 read ignores order", 0, 24'h004410, 2'd0, 1, 16'h0, 0);
    access("R4 normal write",       1, 24'h000500, 2'd0, 0, 16'hBEEF, 0);
    access("R4 reverse write",      1, 24'h000600, 2'd0, 1, 16'h1234, 0);
    access("R2 R4 reverse page write", 1, 24'h0007FF, 2'd1, 1, 16'hA55A, 0);
    access("R6 unmapped read",      0, 24'h7F0010, 2'd0, 0, 16'h0, 0);
    access("R6 R7 half unmapped",   0, 24'h7EFFFF, 2'd0, 0, 16'h0, 0);
    access("R5 dma read blocked",   0, 24'h002140, 2'd0, 0, 16'h0, 1);
    access("R5 dma read into page", 0, 24'h0020FF, 2'd0, 0, 16'h0, 1);
    access("R5 dma write out of page", 1, 24'h0021FF, 2'd0, 0, 16'hC3D4, 1);
    access("R5 page no dma",        0, 24'h002100, 2'd0, 0, 16'h0, 0);
    access("R7 write keeps open bus", 1, 24'h000900, 2'd2, 1, 16'h7788, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule